// File: doc/BRIEF.md
# PCI Inbound Window Address Translator

This block decides where an inbound PCI memory access lands in the AHB system address space. It compares the PCI address against six base-address windows. Each window has a size fixed at design time, which is a power of two, and each window can be switched on or off on its own. The block reports whether a window matched and which one. It then forms the AHB address. When translation is on, the bits above the window size are replaced by that window's own translation value. When translation is off, the PCI address is passed through unchanged.

The external bus may only reach the lower 2 GB of system memory. Any result with address bit 31 set is therefore refused, and so is any request that hits no window. In both cases an error flag is raised and no AHB request is issued.

All outputs are registered. A request strobe in one cycle yields its result on the outputs one clock edge later.

Top module: `pci_win_xlate`

## Requirements
- R1: Window w matches when the PCI address bits at and above position L(w) equal the same bits of that window's base value. L(w) is fixed per window: L = 24, 26, 20, 12, 28, 27 for windows 0 to 5. Base w is `bar_base_i[32*w +: 32]`.
- R2: A window whose bit in `win_en_i` (bit w for window w) is 0 never matches, whatever its base value.
- R3: When more than one enabled window matches, the lowest-numbered one is reported on `win_idx_o` and used for translation.
- R4: With `xlate_en_i` = 1, the output address is (T(w) << L(w)) OR (PCI address AND (2^L(w) − 1)), where T(w) is `xlate_val_i[32*w +: 32]`. For example, window 1 (64 MB) with T = 0x08 maps 0xFC00_1234 to 0x2000_1234.
- R5: With `xlate_en_i` = 0 and a window matched, the output address equals the PCI address.
- R6: If a window matched but the resulting address has bit 31 set, `err_o` is 1, `ahb_req_o` is 0 and `hit_o` stays 1. This applies in both translation modes.
- R7: If no window matched a request, then `hit_o` = 0, `err_o` = 1, `ahb_req_o` = 0, and both `win_idx_o` and `ahb_addr_o` are 0.
- R8: The outputs change one clock edge after the request strobe. `valid_o` equals the strobe of the previous cycle. In a cycle after no strobe, `hit_o`, `err_o` and `ahb_req_o` are 0, while `win_idx_o` and `ahb_addr_o` hold their last values.
- R9: While reset is asserted (`rst_n` low), every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe for the address on `pci_addr_i` |
| pci_addr_i | input | 32 | Inbound PCI memory address |
| bar_base_i | input | 192 | Six base values, window w at bits [32w+31:32w] |
| win_en_i | input | 6 | Enable for each window, bit w for window w |
| xlate_val_i | input | 192 | Six translation values, window w at bits [32w+31:32w] |
| xlate_en_i | input | 1 | Global translation enable |
| valid_o | output | 1 | Result valid, one cycle after `req_i` |
| hit_o | output | 1 | An enabled window matched |
| win_idx_o | output | 3 | Index of the chosen window |
| ahb_addr_o | output | 32 | Resulting AHB address |
| ahb_req_o | output | 1 | The address may be issued on the AHB side |
| err_o | output | 1 | No match, or the result lies above 2 GB |

## Verification
The case that is hardest to reach from the ports is two enabled windows matching the same address, since the windows normally do not overlap. The bench places the 1 MB window inside the 16 MB window on purpose. It then hits the shared range twice: once with both windows enabled, and once with the lower-numbered window disabled, so that priority and the enable gate are both checked against the same address. The bench also reaches the above-2 GB refusal in two ways: through a translation value that lands high, and through pass-through of a high PCI address. This shows the range check acts on the final address in both modes.

// File: rtl/pwx_pkg.sv
package pwx_pkg;

    localparam int unsigned NUM_WIN = 6;
    localparam int unsigned IDX_W   = $clog2(NUM_WIN);

    // log2 of each window size in bytes
    localparam int unsigned WIN_LOG2_DEF [NUM_WIN] = '{24, 26, 20, 12, 28, 27};

endpackage

// File: rtl/pwx_window.sv
module pwx_window #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LOG2   = 12
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] xval_i,
    output logic              match_o,
    output logic [ADDR_W-1:0] mapped_o
);
    localparam logic [ADDR_W-1:0] HI_MASK = {ADDR_W{1'b1}} << LOG2;

    always_comb begin
        match_o  = en_i && ((addr_i & HI_MASK) == (base_i & HI_MASK));
        mapped_o = (xval_i << LOG2) | (addr_i & ~HI_MASK);
    end
endmodule

// File: rtl/pwx_prio_pick.sv
module pwx_prio_pick #(
    parameter int unsigned N     = 6,
    parameter int unsigned IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pwx_addr_sel.sv
module pwx_addr_sel #(
    parameter int unsigned N      = 6,
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned ADDR_W = 32
) (
    input  logic [N*ADDR_W-1:0] cand_i,
    input  logic [IDX_W-1:0]    idx_i,
    output logic [ADDR_W-1:0]   addr_o
);
    always_comb begin
        addr_o = '0;
        for (int i = 0; i < N; i++) begin
            if (idx_i == IDX_W'(i)) begin
                addr_o = cand_i[i*ADDR_W +: ADDR_W];
            end
        end
    end
endmodule

// File: rtl/pci_win_xlate.sv
module pci_win_xlate
    import pwx_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned WIN_LOG2 [NUM_WIN] = WIN_LOG2_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_i,
    input  logic [ADDR_W-1:0]         pci_addr_i,
    input  logic [NUM_WIN*ADDR_W-1:0] bar_base_i,
    input  logic [NUM_WIN-1:0]        win_en_i,
    input  logic [NUM_WIN*ADDR_W-1:0] xlate_val_i,
    input  logic                      xlate_en_i,
    output logic                      valid_o,
    output logic                      hit_o,
    output logic [IDX_W-1:0]          win_idx_o,
    output logic [ADDR_W-1:0]         ahb_addr_o,
    output logic                      ahb_req_o,
    output logic                      err_o
);
    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic              ahb_req;
        logic              err;
    } out_t;

    out_t out_d, out_q;

    logic [NUM_WIN-1:0]        match;
    logic [NUM_WIN*ADDR_W-1:0] mapped;
    logic                      any_hit;
    logic [IDX_W-1:0]          sel_idx;
    logic [ADDR_W-1:0]         sel_addr;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        pwx_window #(
            .ADDR_W (ADDR_W),
            .LOG2   (WIN_LOG2[w])
        ) i_window (
            .en_i     (win_en_i[w]),
            .addr_i   (pci_addr_i),
            .base_i   (bar_base_i[w*ADDR_W +: ADDR_W]),
            .xval_i   (xlate_val_i[w*ADDR_W +: ADDR_W]),
            .match_o  (match[w]),
            .mapped_o (mapped[w*ADDR_W +: ADDR_W])
        );
    end

    pwx_prio_pick #(
        .N     (NUM_WIN),
        .IDX_W (IDX_W)
    ) i_prio (
        .req_i (match),
        .any_o (any_hit),
        .idx_o (sel_idx)
    );

    pwx_addr_sel #(
        .N      (NUM_WIN),
        .IDX_W  (IDX_W),
        .ADDR_W (ADDR_W)
    ) i_sel (
        .cand_i (mapped),
        .idx_i  (sel_idx),
        .addr_o (sel_addr)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = req_i;
        if (req_i) begin
            out_d.hit = any_hit;
            out_d.idx = any_hit ? sel_idx : '0;
            if (!any_hit) begin
                out_d.addr = '0;
            end else if (xlate_en_i) begin
                out_d.addr = sel_addr;
            end else begin
                out_d.addr = pci_addr_i;
            end
            out_d.err     = !any_hit || out_d.addr[ADDR_W-1];
            out_d.ahb_req = !out_d.err;
        end else begin
            out_d.hit     = 1'b0;
            out_d.err     = 1'b0;
            out_d.ahb_req = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o    = out_q.valid;
    assign hit_o      = out_q.hit;
    assign win_idx_o  = out_q.idx;
    assign ahb_addr_o = out_q.addr;
    assign ahb_req_o  = out_q.ahb_req;
    assign err_o      = out_q.err;
endmodule

// File: rtl/pwx_checker.sv
module pwx_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned N      = 6,
    parameter int unsigned IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic [ADDR_W-1:0] pci_addr_i,
    input logic [N-1:0]      win_en_i,
    input logic              xlate_en_i,
    input logic              valid_o,
    input logic              hit_o,
    input logic [IDX_W-1:0]  win_idx_o,
    input logic [ADDR_W-1:0] ahb_addr_o,
    input logic              ahb_req_o,
    input logic              err_o
);
    logic              started_q;
    logic              req_q;
    logic              xen_q;
    logic [N-1:0]      en_q;
    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            req_q     <= 1'b0;
            xen_q     <= 1'b0;
            en_q      <= '0;
            addr_q    <= '0;
        end else begin
            started_q <= 1'b1;
            req_q     <= req_i;
            xen_q     <= xlate_en_i;
            en_q      <= win_en_i;
            addr_q    <= pci_addr_i;
        end
    end

    // R8
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> valid_o == req_q);

    // R8
    idle_flags_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> !hit_o && !err_o && !ahb_req_o);

    // R6
    req_only_low_2g_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ahb_req_o |-> hit_o && !err_o && !ahb_addr_o[ADDR_W-1]);

    // R7
    miss_is_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o && !hit_o |-> err_o && !ahb_req_o && ahb_addr_o == '0);

    // R2
    hit_window_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && hit_o |-> en_q[win_idx_o]);

    // R5
    passthrough_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        started_q && valid_o && hit_o && !xen_q |-> ahb_addr_o == addr_q);
endmodule

bind pci_win_xlate pwx_checker #(
    .ADDR_W (ADDR_W),
    .N      (pwx_pkg::NUM_WIN),
    .IDX_W  (pwx_pkg::IDX_W)
) i_pwx_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .pci_addr_i (pci_addr_i),
    .win_en_i   (win_en_i),
    .xlate_en_i (xlate_en_i),
    .valid_o    (valid_o),
    .hit_o      (hit_o),
    .win_idx_o  (win_idx_o),
    .ahb_addr_o (ahb_addr_o),
    .ahb_req_o  (ahb_req_o),
    .err_o      (err_o)
);

// File: tb/test_pci_win_xlate.sv
module test_pci_win_xlate;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_i = 1'b0;
    logic [31:0]  pci_addr_i = '0;
    logic [191:0] bar_base_i;
    logic [5:0]   win_en_i = '0;
    logic [191:0] xlate_val_i;
    logic         xlate_en_i = 1'b0;
    logic         valid_o, hit_o, ahb_req_o, err_o;
    logic [2:0]   win_idx_o;
    logic [31:0]  ahb_addr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // window 2 (1 MB) lies inside window 0 (16 MB) on purpose
    assign bar_base_i  = {32'h9000_0000, 32'h8000_0000, 32'h4000_1000,
                          32'h1000_0000, 32'hFC00_0000, 32'h1000_0000};
    assign xlate_val_i = {32'h0000_0003, 32'h0000_0009, 32'h0000_0020,
                          32'h0000_0123, 32'h0000_0008, 32'h0000_0005};

    pci_win_xlate i_pci_win_xlate (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .pci_addr_i  (pci_addr_i),
        .bar_base_i  (bar_base_i),
        .win_en_i    (win_en_i),
        .xlate_val_i (xlate_val_i),
        .xlate_en_i  (xlate_en_i),
        .valid_o     (valid_o),
        .hit_o       (hit_o),
        .win_idx_o   (win_idx_o),
        .ahb_addr_o  (ahb_addr_o),
        .ahb_req_o   (ahb_req_o),
        .err_o       (err_o)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [5:0]  en;
        logic        xen;
        logic        hit;
        logic [2:0]  idx;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'hFC00_1234, 6'h3F, 1'b1, 1'b1, 3'd1, 32'h2000_1234, 1'b0},
        '{32'hFC00_1234, 6'h3F, 1'b0, 1'b1, 3'd1, 32'hFC00_1234, 1'b1},
        '{32'h1000_0040, 6'h3F, 1'b1, 1'b1, 3'd0, 32'h0500_0040, 1'b0},
        '{32'h1000_0040, 6'h3E, 1'b1, 1'b1, 3'd2, 32'h1230_0040, 1'b0},
        '{32'h1050_0000, 6'h3E, 1'b1, 1'b0, 3'd0, 32'h0000_0000, 1'b1},
        '{32'h4000_1FFC, 6'h3F, 1'b1, 1'b1, 3'd3, 32'h0002_0FFC, 1'b0},
        '{32'h4000_2000, 6'h3F, 1'b1, 1'b0, 3'd0, 32'h0000_0000, 1'b1},
        '{32'h8ABC_DEF0, 6'h3F, 1'b1, 1'b1, 3'd4, 32'h9ABC_DEF0, 1'b1},
        '{32'h9123_4567, 6'h3F, 1'b1, 1'b1, 3'd5, 32'h1923_4567, 1'b0},
        '{32'h9123_4567, 6'h1F, 1'b1, 1'b0, 3'd0, 32'h0000_0000, 1'b1},
        '{32'h1000_0040, 6'h00, 1'b1, 1'b0, 3'd0, 32'h0000_0000, 1'b1},
        '{32'h1000_0040, 6'h3F, 1'b0, 1'b1, 3'd0, 32'h1000_0040, 1'b0},
        '{32'h10FF_FFFF, 6'h3F, 1'b1, 1'b1, 3'd0, 32'h05FF_FFFF, 1'b0},
        '{32'h1100_0000, 6'h3F, 1'b1, 1'b0, 3'd0, 32'h0000_0000, 1'b1},
        '{32'hFC00_1234, 6'h3D, 1'b1, 1'b0, 3'd0, 32'h0000_0000, 1'b1}
    };
    localparam string TAGS [NV] = '{
        "R4 64MB example", "R6 passthrough above 2GB", "R3 overlap lowest wins",
        "R2 overlap low window off", "R7 miss", "R1 4KB window top",
        "R7 just past 4KB window", "R6 translated above 2GB", "R4 128MB window",
        "R2 window5 disabled", "R2 all disabled", "R5 passthrough",
        "R1 last byte of 16MB", "R1 first byte past 16MB", "R2 window1 disabled"
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic [31:0] a, input logic [5:0] en,
                         input logic xen);
        req_i      = r;
        pci_addr_i = a;
        win_en_i   = en;
        xlate_en_i = xen;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 valid in reset", 32'(valid_o), 32'd0);
        chk("R9 addr in reset", ahb_addr_o, 32'd0);
        chk("R9 flags in reset", {28'd0, hit_o, err_o, ahb_req_o, 1'b0}, 32'd0);
        chk("R9 idx in reset", 32'(win_idx_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].addr, VECS[i].en, VECS[i].xen);
            @(negedge clk);
            chk({TAGS[i], " R8 valid"}, 32'(valid_o), 32'd1);
            chk({TAGS[i], " hit"}, 32'(hit_o), 32'(VECS[i].hit));
            chk({TAGS[i], " idx"}, 32'(win_idx_o), 32'(VECS[i].idx));
            chk({TAGS[i], " addr"}, ahb_addr_o, VECS[i].exp);
            chk({TAGS[i], " err"}, 32'(err_o), 32'(VECS[i].err));
            chk({TAGS[i], " ahb_req"}, 32'(ahb_req_o),
                32'(VECS[i].hit && !VECS[i].err));
        end

        // R8 idle: flags drop, address and index hold
        drive(1'b1, 32'h9123_4567, 6'h3F, 1'b1);
        @(negedge clk);
        drive(1'b0, 32'h1000_0040, 6'h3F, 1'b1);
        @(negedge clk);
        chk("R8 idle valid", 32'(valid_o), 32'd0);
        chk("R8 idle flags", {29'd0, hit_o, err_o, ahb_req_o}, 32'd0);
        chk("R8 idle addr hold", ahb_addr_o, 32'h1923_4567);
        chk("R8 idle idx hold", 32'(win_idx_o), 32'd5);

        // R8 latency: nothing changes before the edge
        drive(1'b1, 32'hFC00_0000, 6'h3F, 1'b1);
        #1;
        chk("R8 no change before edge", 32'(valid_o), 32'd0);
        @(negedge clk);
        chk("R8 one cycle later valid", 32'(valid_o), 32'd1);
        chk("R4 R8 one cycle later addr", ahb_addr_o, 32'h2000_0000);

        // R9 reset during activity
        rst_n = 1'b0;
        #1;
        chk("R9 mid-run reset addr", ahb_addr_o, 32'd0);
        chk("R9 mid-run reset flags", {28'd0, valid_o, hit_o, ahb_req_o, err_o}, 32'd0);
        drive(1'b0, 32'd0, 6'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule